// File: doc/BRIEF.md
# Multiplexed Expansion Bus Cycle Sampler

This block follows an 8-bit expansion bus that carries a 16-bit address. The high address byte, the low address byte and the data byte all reach the chip through one shared 8-bit input. External transceivers decide which of the three is visible, and the block steers them with three active-low select lines. Each bus cycle, the sampler takes in both address bytes and branches on the read/write level. It then samples the read/write line, the device-select line and the data byte, and pushes one packed 26-bit record into a small output queue.

All bus inputs pass through a synchronizer before they are used. Every wait inside a bus cycle is a fixed number of core clocks, and each wait is set by a parameter. On a read cycle the block gives a one-clock trigger to a separate data-driver block. Before it starts the next cycle, it waits for that block's busy flag to drop.

Records leave the block on a valid/ready stream. The sampler never stalls for the consumer. While `rec_valid` is high and `rec_ready` is low, the head record and `rec_valid` do not change. A record moves across on every clock where both are high. A record that finds the queue full is discarded, and a sticky flag records the loss.

Top module: `xbus_cycle_sampler`

## Requirements
- R1: `xcvr_sel_n` is {high-address, low-address, data}, active low: 3'b011 picks the high byte, 3'b101 the low byte, 3'b110 data, 3'b111 none. No more than one bit is ever low.
- R2: A cycle starts with the select at 3'b011. The block waits until the synchronized phase clock is high, and the synchronizer is two flops deep by default. On the first core clock where it sees that level, it captures the high address byte from the synchronized bus.
- R3: Next the select goes to 3'b101 for LO_SETTLE+1 core clocks. On the last of these the low byte is captured, and on the same clock the synchronized read/write level picks the branch: high means read, low means write.
- R4: On a write, the select is 3'b110 for WR_WAIT+1 core clocks. On the last of these, the synchronized read/write, device-select and data byte are sampled and a record is pushed.
- R5: On a read, the select is 3'b111 for RD_WAIT+1 core clocks. The same three items are then sampled and pushed, and the data field holds whatever the bus input shows at that point.
- R6: Record layout: [25:18] high address, [17:10] low address, [9] read/write, [8] device-select (active low), [7:0] data.
- R7: `rd_trig` is high for exactly one core clock, in the clock after a read record is sampled. This happens whatever the device-select level is. A write never raises it.
- R8: After the sample, the select holds its value until the synchronized phase clock is low. It then holds for FALL_HOLD+1 more core clocks. A read cycle also waits, at that point, while `drv_busy` is high. Only after this does the select return to 3'b011.
- R9: The queue holds FIFO_DEPTH records and keeps their order. `rec_valid` is high whenever it is not empty. While `rec_valid` is high and `rec_ready` is low, `rec_data` is held.
- R10: A record pushed while the queue holds FIFO_DEPTH records is dropped, even if a record leaves on that same clock. The drop sets `rec_overflow`, which stays high until reset.
- R11: During reset, `xcvr_sel_n` is 3'b011 and `rd_trig`, `rec_valid` and `rec_overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phi0 | input | 1 | Bus phase clock, asynchronous |
| bus_rw | input | 1 | Bus read/write level, high = read |
| bus_devsel_n | input | 1 | Device select, active low |
| bus_d | input | 8 | Shared transceiver byte |
| drv_busy | input | 1 | Read-data driver busy flag |
| rec_ready | input | 1 | Stream consumer ready |
| xcvr_sel_n | output | 3 | Transceiver selects, active low |
| rd_trig | output | 1 | Read-data trigger pulse |
| rec_valid | output | 1 | Stream record valid |
| rec_data | output | 26 | Packed cycle record |
| rec_overflow | output | 1 | Sticky record-dropped flag |

## Verification
The hardest state to reach from the ports is a full queue meeting a new record. Bus cycles are long and the queue drains at any ready edge, so filling it takes deliberate effort. The stimulus holds `rec_ready` low through five complete write cycles and then checks that only the first four come out. The second hard case is a read whose driver stays busy past the fall hold. It is reached by holding `drv_busy` high across most of the low phase and checking that the selects stay parked until the flag drops.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;
  localparam int REC_W  = 3 * BYTE_W + 2;

  // {high-address, low-address, data}, active low
  localparam logic [SEL_W-1:0] SEL_ADDR_HI = 3'b011;
  localparam logic [SEL_W-1:0] SEL_ADDR_LO = 3'b101;
  localparam logic [SEL_W-1:0] SEL_DATA    = 3'b110;
  localparam logic [SEL_W-1:0] SEL_NONE    = 3'b111;

  typedef enum logic [2:0] {
    ST_HI   = 3'd0,
    ST_LO   = 3'd1,
    ST_WR   = 3'd2,
    ST_RD   = 3'd3,
    ST_FALL = 3'd4,
    ST_HOLD = 3'd5
  } phase_e;

  typedef struct packed {
    logic [BYTE_W-1:0] addr_hi;
    logic [BYTE_W-1:0] addr_lo;
    logic              rw;
    logic              devsel_n;
    logic [BYTE_W-1:0] data;
  } bus_rec_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/xbs_sync.sv
module xbs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= din;
      end
      assign dout = q;
    end else begin : g_chain
      logic [W-1:0] chain [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
          chain[0] <= din;
          for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
      end
      assign dout = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/xbs_seq.sv
module xbs_seq
  import xbs_pkg::*;
#(
  parameter int LO_SETTLE = 3,
  parameter int WR_WAIT   = 16,
  parameter int RD_WAIT   = 2,
  parameter int FALL_HOLD = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi0_s,
  input  logic              rw_s,
  input  logic              devsel_n_s,
  input  logic [BYTE_W-1:0] data_s,
  input  logic              drv_busy,
  output logic [SEL_W-1:0]  sel_n,
  output logic              rd_trig,
  output logic              push,
  output logic [REC_W-1:0]  push_rec
);

  localparam int MAX_WAIT = imax(imax(LO_SETTLE, WR_WAIT), imax(RD_WAIT, FALL_HOLD));
  localparam int CNT_W    = $clog2(imax(MAX_WAIT, 1) + 1);
  localparam logic [CNT_W-1:0] C_LO   = CNT_W'(LO_SETTLE);
  localparam logic [CNT_W-1:0] C_WR   = CNT_W'(WR_WAIT);
  localparam logic [CNT_W-1:0] C_RD   = CNT_W'(RD_WAIT);
  localparam logic [CNT_W-1:0] C_HOLD = CNT_W'(FALL_HOLD);

  phase_e            state, nxt;
  logic [CNT_W-1:0]  cnt, lim;
  logic              at_lim;
  logic [BYTE_W-1:0] hi_q, lo_q;
  logic              is_rd;
  bus_rec_t          rec;

  // per-phase dwell limit
  always_comb begin
    unique case (state)
      ST_LO:   lim = C_LO;
      ST_WR:   lim = C_WR;
      ST_RD:   lim = C_RD;
      ST_HOLD: lim = C_HOLD;
      default: lim = '0;
    endcase
  end

  assign at_lim = (cnt == lim);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_HI:   if (phi0_s) nxt = ST_LO;
      ST_LO:   if (at_lim) nxt = rw_s ? ST_RD : ST_WR;
      ST_WR,
      ST_RD:   if (at_lim) nxt = ST_FALL;
      ST_FALL: if (!phi0_s) nxt = ST_HOLD;
      ST_HOLD: if (at_lim && !(is_rd && drv_busy)) nxt = ST_HI;
      default: nxt = ST_HI;
    endcase
  end

  assign push = ((state == ST_WR) || (state == ST_RD)) && at_lim;

  always_comb begin
    rec.addr_hi  = hi_q;
    rec.addr_lo  = lo_q;
    rec.rw       = rw_s;
    rec.devsel_n = devsel_n_s;
    rec.data     = data_s;
  end
  assign push_rec = rec;

  // transceiver steering decoded from phase
  always_comb begin
    unique case (state)
      ST_HI:   sel_n = SEL_ADDR_HI;
      ST_LO:   sel_n = SEL_ADDR_LO;
      ST_WR:   sel_n = SEL_DATA;
      ST_RD:   sel_n = SEL_NONE;
      default: sel_n = is_rd ? SEL_NONE : SEL_DATA;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_HI;
      cnt     <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      is_rd   <= 1'b0;
      rd_trig <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != state)  cnt <= '0;
      else if (!at_lim)  cnt <= cnt + CNT_W'(1);
      if (state == ST_HI && phi0_s) hi_q <= data_s;
      if (state == ST_LO && at_lim) lo_q <= data_s;
      if (push) is_rd <= (state == ST_RD);
      rd_trig <= push && (state == ST_RD);
    end
  end

  AST_ONE_XCVR: assert property (@(posedge clk) disable iff (!rst_n) $countones(~sel_n) <= 1); // R1
  AST_HI_WAITS_PHI: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_HI && !phi0_s) |=> (state == ST_HI)); // R2
  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rd_trig |=> !rd_trig); // R7
  AST_TRIG_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) rd_trig |-> (sel_n == SEL_NONE)); // R7
  AST_BUSY_PARKS: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_HOLD && is_rd && drv_busy) |=> (sel_n == SEL_NONE)); // R8

endmodule

// File: rtl/xbs_fifo.sv
module xbs_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 26
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         overflow
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] C_FULL = CW'(DEPTH);
  localparam logic [AW-1:0] C_LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full, wr, rd;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == C_LAST) ? '0 : p + AW'(1);
  endfunction

  assign full      = (cnt == C_FULL);
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rp];
  assign wr        = in_valid && !full;
  assign rd        = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr) wp <= bump(wp);
      if (rd) rp <= bump(rp);
      unique case ({wr, rd})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
      if (in_valid && full) overflow <= 1'b1;
    end
  end

  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= C_FULL); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overflow |=> overflow); // R10

endmodule

// File: rtl/xbus_cycle_sampler.sv
module xbus_cycle_sampler
  import xbs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LO_SETTLE   = 3,
  parameter int WR_WAIT     = 16,
  parameter int RD_WAIT     = 2,
  parameter int FALL_HOLD   = 8,
  parameter int FIFO_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi0,
  input  logic              bus_rw,
  input  logic              bus_devsel_n,
  input  logic [BYTE_W-1:0] bus_d,
  input  logic              drv_busy,
  input  logic              rec_ready,
  output logic [SEL_W-1:0]  xcvr_sel_n,
  output logic              rd_trig,
  output logic              rec_valid,
  output logic [REC_W-1:0]  rec_data,
  output logic              rec_overflow
);

  localparam int IN_W = BYTE_W + 3;

  logic [IN_W-1:0]   raw_in, syn_in;
  logic              push;
  logic [REC_W-1:0]  push_rec;

  assign raw_in = {phi0, bus_rw, bus_devsel_n, bus_d};

  xbs_sync #(
    .W      (IN_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (raw_in),
    .dout  (syn_in)
  );

  xbs_seq #(
    .LO_SETTLE (LO_SETTLE),
    .WR_WAIT   (WR_WAIT),
    .RD_WAIT   (RD_WAIT),
    .FALL_HOLD (FALL_HOLD)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .phi0_s     (syn_in[IN_W-1]),
    .rw_s       (syn_in[IN_W-2]),
    .devsel_n_s (syn_in[IN_W-3]),
    .data_s     (syn_in[BYTE_W-1:0]),
    .drv_busy   (drv_busy),
    .sel_n      (xcvr_sel_n),
    .rd_trig    (rd_trig),
    .push       (push),
    .push_rec   (push_rec)
  );

  xbs_fifo #(
    .DEPTH (FIFO_DEPTH),
    .W     (REC_W)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (push),
    .in_data   (push_rec),
    .out_valid (rec_valid),
    .out_ready (rec_ready),
    .out_data  (rec_data),
    .overflow  (rec_overflow)
  );

endmodule

// File: tb/tb_xbus_cycle_sampler.sv
module tb_xbus_cycle_sampler;

  localparam int LO_SETTLE = 3, WR_WAIT = 16, RD_WAIT = 2, FALL_HOLD = 8, DEPTH = 4;
  localparam int LOW_T = 20, HIGH_T = 45;
  localparam logic [7:0] JUNK = 8'hA5;

  logic clk = 1'b0, rst_n = 1'b0, phi0 = 1'b0, bus_rw = 1'b0, bus_devsel_n = 1'b1;
  logic drv_busy = 1'b0, rec_ready = 1'b0;
  logic [7:0] bus_d = 8'h00;
  logic [2:0] xcvr_sel_n;
  logic rd_trig, rec_valid, rec_overflow;
  logic [25:0] rec_data;

  logic [7:0] addr_hi = 8'h00, addr_lo = 8'h00, wdata = 8'h00;
  int ready_mode = 1;
  bit cmp_en = 1'b0;
  int cyc = 0;
  int n_tests = 0, n_fail = 0;
  logic [25:0] m_q[$], got_q[$], exp_q[$];

  // behavioural reference state
  int m_phase = 0, m_left = 0;
  logic [7:0] m_hi = 8'h00, m_lo = 8'h00;
  bit m_rd = 1'b0, m_trig = 1'b0, m_ovf = 1'b0;
  logic [10:0] m_s1 = '0, m_s2 = '0;

  always #5 clk = ~clk;

  xbus_cycle_sampler #(
    .SYNC_STAGES (2), .LO_SETTLE (LO_SETTLE), .WR_WAIT (WR_WAIT),
    .RD_WAIT (RD_WAIT), .FALL_HOLD (FALL_HOLD), .FIFO_DEPTH (DEPTH)
  ) dut (
    .clk (clk), .rst_n (rst_n), .phi0 (phi0), .bus_rw (bus_rw),
    .bus_devsel_n (bus_devsel_n), .bus_d (bus_d), .drv_busy (drv_busy),
    .rec_ready (rec_ready), .xcvr_sel_n (xcvr_sel_n), .rd_trig (rd_trig),
    .rec_valid (rec_valid), .rec_data (rec_data), .rec_overflow (rec_overflow)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  function automatic logic [2:0] exp_sel();
    case (m_phase)
      0: return 3'b011;
      1: return 3'b101;
      2: return 3'b110;
      3: return 3'b111;
      default: return m_rd ? 3'b111 : 3'b110;
    endcase
  endfunction

  // reference model: two-deep input delay, phase countdowns, record queue
  always @(posedge clk) begin : model
    logic [10:0] sv;
    logic do_push, was_full, do_pop;
    logic [25:0] rec;
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_hi = 0; m_lo = 0; m_rd = 0; m_trig = 0; m_ovf = 0;
      m_s1 = '0; m_s2 = '0; m_q.delete();
    end else begin
      sv = m_s2;
      do_push = 1'b0; rec = '0;
      was_full = (m_q.size() == DEPTH);
      do_pop = (m_q.size() != 0) && rec_ready;
      m_trig = 1'b0;
      case (m_phase)
        0: if (sv[10]) begin m_hi = sv[7:0]; m_phase = 1; m_left = LO_SETTLE; end
        1: if (m_left == 0) begin
             m_lo = sv[7:0];
             m_phase = sv[9] ? 3 : 2;
             m_left = sv[9] ? RD_WAIT : WR_WAIT;
           end else m_left--;
        2, 3: if (m_left == 0) begin
             do_push = 1'b1;
             rec = {m_hi, m_lo, sv[9], sv[8], sv[7:0]};
             m_rd = (m_phase == 3);
             m_trig = m_rd;
             m_phase = 4;
           end else m_left--;
        4: if (!sv[10]) begin m_phase = 5; m_left = FALL_HOLD; end
        default: if (m_left == 0) begin
             if (!(m_rd && drv_busy)) m_phase = 0;
           end else m_left--;
      endcase
      if (do_pop) void'(m_q.pop_front());
      if (do_push) begin
        if (was_full) m_ovf = 1'b1;
        else m_q.push_back(rec);
      end
      m_s2 = m_s1;
      m_s1 = {phi0, bus_rw, bus_devsel_n, bus_d};
    end
  end

  // per-clock comparison, consumer and transceiver model
  always @(negedge clk) begin : edge_side
    logic nr;
    cyc++;
    if (cmp_en) begin
      chk("R1 sel", 32'(xcvr_sel_n), 32'(exp_sel()));
      chk("R7 trig", 32'(rd_trig), 32'(m_trig));
      chk("R9 valid", 32'(rec_valid), 32'(m_q.size() != 0));
      if (m_q.size() != 0) chk("R6 data", 32'(rec_data), 32'(m_q[0]));
      chk("R10 ovf", 32'(rec_overflow), 32'(m_ovf));
    end
    case (ready_mode)
      0: nr = 1'b0;
      1: nr = 1'b1;
      default: nr = (cyc % 3) != 0;
    endcase
    if (rst_n && rec_valid && nr) got_q.push_back(rec_data);
    rec_ready <= nr;
    case (xcvr_sel_n)
      3'b011: bus_d <= addr_hi;
      3'b101: bus_d <= addr_lo;
      3'b110: bus_d <= wdata;
      default: bus_d <= JUNK;
    endcase
  end

  task automatic bus_cycle(input logic [7:0] ah, input logic [7:0] al, input logic rw,
                           input logic dv, input logic [7:0] wd, input int busy_n);
    addr_hi = ah; addr_lo = al; wdata = wd; bus_rw = rw; bus_devsel_n = dv;
    exp_q.push_back({ah, al, rw, dv, rw ? JUNK : wd});
    step(LOW_T);
    phi0 = 1'b1;
    step(HIGH_T);
    phi0 = 1'b0;
    drv_busy = (busy_n > 0);
    step(5);
    chk("R8 hold", 32'(xcvr_sel_n), rw ? 32'h7 : 32'h6);
    if (busy_n > 0) begin
      step(busy_n - 5);
      chk("R8 busy", 32'(xcvr_sel_n), 32'h7);
      drv_busy = 1'b0;
      step(3);
      chk("R8 release", 32'(xcvr_sel_n), 32'h3);
    end
  endtask

  task automatic drain_check();
    chk("R9 count", 32'(got_q.size()), 32'(exp_q.size()));
    while (got_q.size() != 0 && exp_q.size() != 0) begin
      logic [25:0] g, e;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      chk("R2 hi", 32'(g[25:18]), 32'(e[25:18]));
      chk("R3 lo", 32'(g[17:10]), 32'(e[17:10]));
      if (e[9]) chk("R5 read", 32'(g[9:0]), 32'(e[9:0]));
      else      chk("R4 write", 32'(g[9:0]), 32'(e[9:0]));
    end
    got_q.delete();
    exp_q.delete();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R8 watchdog act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    step(3);
    chk("R11 sel", 32'(xcvr_sel_n), 32'h3);
    chk("R11 trig", 32'(rd_trig), 32'h0);
    chk("R11 valid", 32'(rec_valid), 32'h0);
    chk("R11 ovf", 32'(rec_overflow), 32'h0);
    rst_n = 1'b1; cmp_en = 1'b1;
    step(5);

    // mixed writes and reads, consumer always ready
    ready_mode = 1;
    bus_cycle(8'h12, 8'h34, 1'b0, 1'b0, 8'h56, 0);
    bus_cycle(8'hC0, 8'h01, 1'b1, 1'b0, 8'h00, 25);
    bus_cycle(8'hFF, 8'h00, 1'b0, 1'b1, 8'h81, 0);
    bus_cycle(8'h00, 8'hFF, 1'b1, 1'b1, 8'h00, 0);
    step(5);
    drain_check();

    // consumer with gaps
    ready_mode = 2;
    bus_cycle(8'hA0, 8'h0A, 1'b0, 1'b0, 8'h3C, 0);
    bus_cycle(8'h5B, 8'hB5, 1'b1, 1'b0, 8'h00, 22);
    bus_cycle(8'h7E, 8'hE7, 1'b0, 1'b1, 8'hC3, 0);
    step(10);
    drain_check();

    // fill the queue with the consumer stalled; fifth record must drop
    ready_mode = 0;
    for (int i = 0; i < 5; i++)
      bus_cycle(8'h40 + 8'(i), 8'h90 - 8'(i), 1'b0, 1'b0, 8'h10 * 8'(i), 0);
    void'(exp_q.pop_back());
    chk("R10 set", 32'(rec_overflow), 32'h1);
    chk("R9 held", 32'(rec_valid), 32'h1);
    ready_mode = 1;
    step(10);
    drain_check();
    bus_cycle(8'h21, 8'h43, 1'b1, 1'b0, 8'h00, 0);
    step(5);
    chk("R10 sticky", 32'(rec_overflow), 32'h1);
    drain_check();

    // reset clears the flag
    cmp_en = 1'b0;
    rst_n = 1'b0;
    step(2);
    chk("R11 sel", 32'(xcvr_sel_n), 32'h3);
    chk("R11 ovf", 32'(rec_overflow), 32'h0);
    chk("R11 valid", 32'(rec_valid), 32'h0);
    chk("R11 trig", 32'(rd_trig), 32'h0);
    rst_n = 1'b1; cmp_en = 1'b1;
    step(3);
    bus_cycle(8'h99, 8'h66, 1'b0, 1'b1, 8'hF0, 0);
    step(5);
    drain_check();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule